// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the station-management master for an Ethernet PHY management bus. It divides the system clock down to a slow management clock and sends complete read or write frames on a bidirectional data line. The data line is exposed as three signals: a driven value, an output enable and a sampled input. The host offers one request at a time through a valid/ready handshake. A request carries the direction, a PHY address, a register address and, for a write, a 16-bit data word. The block later pulses `done_o` once and presents the read word and an error flag in that cycle.

On a read, the block checks that the PHY pulled the line low in the released turnaround slot. If the line is still high, the PHY has lost frame alignment. The block then keeps the line released, clocks a fixed number of recovery cycles so the PHY can resynchronise, and ends the request with the error flag set. Every frame also ends with one trailing released clock.

`mdio_i` is assumed to be synchronous to `clk` already. Any synchronizer sits outside this block.

Top module: `mdio_master`

## Requirements
- R1: After reset and between transactions, `req_ready_o` is 1, `mdc_o` is 0 and `mdio_oe_o` is 0.
- R2: A request is taken only on a cycle where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` is 0 on the next cycle. Request fields are captured on acceptance, so changing them later does not alter the frame. A valid held while busy starts nothing.
- R3: While a frame runs, `mdc_o` has a low phase and a high phase of exactly HALF_DIV system clocks each. Each frame starts with a low phase.
- R4: The first 32 management clocks of every frame carry `mdio_oe_o`=1 and `mdio_o`=1.
- R5: The next 14 clocks carry, MSB first, the start pair 0,1. Then comes the opcode: 1,0 for a read or 0,1 for a write. Then come the 5-bit PHY address and the 5-bit register address.
- R6: `mdio_o` and `mdio_oe_o` change only while `mdc_o` is low. They are stable for every cycle that `mdc_o` is high.
- R7: A write then drives 1,0 and the 16 data bits MSB first. It ends with one released clock (`mdio_oe_o`=0), for 65 management clocks in total. It then finishes with `err_o`=0 and `rd_data_o`=0.
- R8: A read releases the line for the turnaround clock and samples it at the end of that high phase. If the sample is 0, the block samples 16 data bits MSB first at the end of each high phase, then adds one released clock, for 64 clocks in total. It finishes with `err_o`=0 and the sampled word on `rd_data_o`.
- R9: If the turnaround sample of a read is 1, the block keeps the line released for 32 more clocks, for 79 in total. It then finishes with `err_o`=1 and `rd_data_o`=0.
- R10: `done_o` is high for exactly one cycle per transaction. `rd_data_o` and `err_o` are valid in that cycle and hold until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_read_i | input | 1 | 1 = read, 0 = write |
| req_phy_i | input | ADDR_W | PHY address |
| req_reg_i | input | ADDR_W | Register address |
| req_wdata_i | input | DATA_W | Write data |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven onto the data line |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Sampled data line |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | DATA_W | Read result, 0 on writes and errors |
| err_o | output | 1 | Turnaround error on the last read |

## Verification
The hardest path to reach is the turnaround failure. From the ports it needs a PHY that leaves the line high in exactly one released slot, and then behaves again on the next request. The bench holds a small PHY model that counts rising management-clock edges and drives `mdio_i` from that index. It drives 0 or 1 in slot 46 on request, and the read word in slots 47 to 62. The error read, with its 32 recovery clocks, is followed by a normal read to show that the block recovers.

// File: rtl/mdio_pkg.sv
// Package: shared state encoding and the fixed bit patterns of a management frame.
// Assumes a clause-22 frame: start pair, two-bit opcode, two addresses, turnaround, data.
package mdio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_WDAT,
        ST_RTA,
        ST_RDAT,
        ST_TAIL,
        ST_RECOV
    } mdio_state_t;

    localparam logic [1:0] START_PAT = 2'b01;
    localparam logic [1:0] OP_READ   = 2'b10;
    localparam logic [1:0] OP_WRITE  = 2'b01;
    localparam logic [1:0] TA_WRITE  = 2'b10;

endpackage

// File: rtl/mdio_mdc_gen.sv
// Module: management clock divider.
// While run_i is high it toggles mdc_o every HALF_DIV system clocks, starting low.
// It flags the last system cycle of each high phase, which is the bit boundary.
// Assumes HALF_DIV >= 1. With run_i low, mdc_o rests low and the count is cleared.
module mdio_mdc_gen #(
    parameter int HALF_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic mdc_o,
    output logic bit_end_o
);

    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             mdc_q;

    // Half-period counter and clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!run_i) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The falling edge that closes a high phase marks the end of one bit.
    assign bit_end_o = run_i && mdc_q && (cnt_q == LAST);
    assign mdc_o     = mdc_q;

endmodule

// File: rtl/mdio_rx_shift.sv
// Module: read-data capture register.
// Shifts one sampled bit in at the LSB per strobe, so the first bit lands as MSB.
// It is cleared when a new request is accepted.
module mdio_rx_shift #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] sr_q;

    // Clear on a new request, shift MSB-first on each sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (clr_i) begin
            sr_q <= '0;
        end else if (shift_i) begin
            sr_q <= {sr_q[DATA_W-2:0], bit_i};
        end
    end

    assign data_o = sr_q;

endmodule

// File: rtl/mdio_frame_ctl.sv
// Module: frame sequencer.
// Walks the phases of a management frame, one phase per state, advancing on each bit boundary.
// All outgoing bits sit in one shift register loaded at acceptance.
// It samples mdio_i on the last system cycle of each high phase.
// Assumes mdio_i is already synchronous to clk.
module mdio_frame_ctl
    import mdio_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int PRE_LEN   = 32,
    parameter int RECOV_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic              req_read_i,
    input  logic [ADDR_W-1:0] req_phy_i,
    input  logic [ADDR_W-1:0] req_reg_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic              bit_end_i,
    input  logic              mdio_i,
    output logic              run_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    output logic              rx_clr_o,
    output logic              rx_shift_o,
    input  logic [DATA_W-1:0] rx_data_i,
    output logic              done_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              err_o
);

    localparam int HDR_W = 4 + 2 * ADDR_W;
    localparam int WR_W  = DATA_W + 2;
    localparam int FR_W  = HDR_W + WR_W;
    localparam int L1    = (PRE_LEN > RECOV_LEN) ? PRE_LEN : RECOV_LEN;
    localparam int L2    = (L1 > WR_W) ? L1 : WR_W;
    localparam int L3    = (L2 > HDR_W) ? L2 : HDR_W;
    localparam int CNT_W = $clog2(L3 + 1);

    localparam logic [CNT_W-1:0] PRE_LAST   = CNT_W'(PRE_LEN - 1);
    localparam logic [CNT_W-1:0] HDR_LAST   = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] WR_LAST    = CNT_W'(WR_W - 1);
    localparam logic [CNT_W-1:0] RD_LAST    = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] RECOV_LAST = CNT_W'(RECOV_LEN - 1);

    mdio_state_t       state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [FR_W-1:0]   sr_q;
    logic              rd_q;
    logic              done_q;
    logic              err_q;
    logic [DATA_W-1:0] rdata_q;
    logic              accept;

    assign accept = (state_q == ST_IDLE) && req_valid_i;

    // Phase sequencing, bit counting, output shift and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sr_q    <= '0;
            rd_q    <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_PRE;
                        cnt_q   <= '0;
                        rd_q    <= req_read_i;
                        sr_q    <= {START_PAT, (req_read_i ? OP_READ : OP_WRITE),
                                    req_phy_i, req_reg_i, TA_WRITE, req_wdata_i};
                    end
                end
                ST_PRE: begin
                    if (bit_end_i) begin
                        if (cnt_q == PRE_LAST) begin
                            state_q <= ST_HDR;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_HDR: begin
                    if (bit_end_i) begin
                        sr_q <= sr_q << 1;
                        if (cnt_q == HDR_LAST) begin
                            cnt_q   <= '0;
                            state_q <= rd_q ? ST_RTA : ST_WDAT;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_WDAT: begin
                    if (bit_end_i) begin
                        sr_q <= sr_q << 1;
                        if (cnt_q == WR_LAST) begin
                            cnt_q   <= '0;
                            state_q <= ST_TAIL;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_RTA: begin
                    if (bit_end_i) begin
                        cnt_q   <= '0;
                        state_q <= mdio_i ? ST_RECOV : ST_RDAT;
                    end
                end
                ST_RDAT: begin
                    if (bit_end_i) begin
                        if (cnt_q == RD_LAST) begin
                            cnt_q   <= '0;
                            state_q <= ST_TAIL;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_TAIL: begin
                    if (bit_end_i) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        err_q   <= 1'b0;
                        rdata_q <= rd_q ? rx_data_i : '0;
                    end
                end
                ST_RECOV: begin
                    if (bit_end_i) begin
                        if (cnt_q == RECOV_LAST) begin
                            cnt_q   <= '0;
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                            err_q   <= 1'b1;
                            rdata_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Line drive: ones in the preamble, shift-register MSB while the master owns the line.
    always_comb begin
        mdio_oe_o = (state_q == ST_PRE) || (state_q == ST_HDR) || (state_q == ST_WDAT);
        if (state_q == ST_PRE) begin
            mdio_o = 1'b1;
        end else if (mdio_oe_o) begin
            mdio_o = sr_q[FR_W-1];
        end else begin
            mdio_o = 1'b0;
        end
    end

    assign req_ready_o = (state_q == ST_IDLE);
    assign run_o       = (state_q != ST_IDLE);
    assign rx_clr_o    = accept;
    assign rx_shift_o  = (state_q == ST_RDAT) && bit_end_i;
    assign done_o      = done_q;
    assign err_o       = err_q;
    assign rd_data_o   = rdata_q;

endmodule

// File: rtl/mdio_master.sv
// Module: management-bus master top.
// Joins the clock divider, the frame sequencer and the read capture register.
// Assumes mdio_i is synchronous to clk, and that the pad combines mdio_o/mdio_oe_o into a tristate driver.
module mdio_master #(
    parameter int HALF_DIV  = 10,
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int PRE_LEN   = 32,
    parameter int RECOV_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic              req_read_i,
    input  logic [ADDR_W-1:0] req_phy_i,
    input  logic [ADDR_W-1:0] req_reg_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    input  logic              mdio_i,
    output logic              done_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              err_o
);

    logic              run;
    logic              bit_end;
    logic              rx_clr;
    logic              rx_shift;
    logic [DATA_W-1:0] rx_data;

    mdio_mdc_gen #(
        .HALF_DIV (HALF_DIV)
    ) u_mdc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .mdc_o     (mdc_o),
        .bit_end_o (bit_end)
    );

    mdio_frame_ctl #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .PRE_LEN   (PRE_LEN),
        .RECOV_LEN (RECOV_LEN)
    ) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_ready_o (req_ready_o),
        .req_read_i  (req_read_i),
        .req_phy_i   (req_phy_i),
        .req_reg_i   (req_reg_i),
        .req_wdata_i (req_wdata_i),
        .bit_end_i   (bit_end),
        .mdio_i      (mdio_i),
        .run_o       (run),
        .mdio_o      (mdio_o),
        .mdio_oe_o   (mdio_oe_o),
        .rx_clr_o    (rx_clr),
        .rx_shift_o  (rx_shift),
        .rx_data_i   (rx_data),
        .done_o      (done_o),
        .rd_data_o   (rd_data_o),
        .err_o       (err_o)
    );

    mdio_rx_shift #(
        .DATA_W (DATA_W)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (rx_clr),
        .shift_i (rx_shift),
        .bit_i   (mdio_i),
        .data_o  (rx_data)
    );

endmodule

// File: rtl/mdio_master_chk.sv
// Module: protocol checker bound to the master top; observes its ports only.
module mdio_master_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_i,
    input logic              req_ready_o,
    input logic              mdc_o,
    input logic              mdio_o,
    input logic              mdio_oe_o,
    input logic              done_o,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              err_o
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> (!mdc_o && !mdio_oe_o)); // R1

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> !req_ready_o); // R2

    AST_HIGH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mdc_o |-> ($stable(mdio_o) && $stable(mdio_oe_o))); // R6

    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!mdio_oe_o && !mdc_o)); // R7

    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> (rd_data_o == '0)); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10

endmodule

bind mdio_master mdio_master_chk #(
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .mdc_o       (mdc_o),
    .mdio_o      (mdio_o),
    .mdio_oe_o   (mdio_oe_o),
    .done_o      (done_o),
    .rd_data_o   (rd_data_o),
    .err_o       (err_o)
);

// File: tb/mdio_master_tb_top.sv
// Bench: sweeps every PHY address through writes and reads, then covers the edge cases.
// A PHY model is keyed on the count of rising management-clock edges. The clock period is 20 time units (50 MHz).
module mdio_master_tb_top;

    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic        req_read;
    logic [4:0]  req_phy;
    logic [4:0]  req_reg;
    logic [15:0] req_wdata;
    logic        mdc;
    logic        mdio_out;
    logic        mdio_oe;
    logic        mdio_in;
    logic        done;
    logic [15:0] rd_data;
    logic        err;

    int checks = 0;
    int errors = 0;

    // Monitor and PHY model state
    int          nrise = 0;
    int          done_cnt = 0;
    int          phase_bad = 0;
    int          stab_bad = 0;
    int          run_len = 0;
    logic        last_mdc = 1'b0;
    logic        oe_rec [0:127];
    logic        do_rec [0:127];
    logic        got_err;
    logic [15:0] got_rd;
    logic        mon_read = 1'b0;
    logic        mon_tabad = 1'b0;
    logic [15:0] mon_rv = '0;

    always #10 clk = ~clk;

    mdio_master #(
        .HALF_DIV (HALF)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid),
        .req_ready_o (req_ready),
        .req_read_i  (req_read),
        .req_phy_i   (req_phy),
        .req_reg_i   (req_reg),
        .req_wdata_i (req_wdata),
        .mdc_o       (mdc),
        .mdio_o      (mdio_out),
        .mdio_oe_o   (mdio_oe),
        .mdio_i      (mdio_in),
        .done_o      (done),
        .rd_data_o   (rd_data),
        .err_o       (err)
    );

    // What the PHY puts on the line for rising edge k of a frame (pull-up when not driving).
    function automatic logic phy_bit(int k);
        if (mon_read && k == 46) return mon_tabad;
        if (mon_read && k >= 47 && k <= 62) return mon_rv[62-k];
        return 1'b1;
    endfunction

    // Expected {oe, value} for rising edge k.
    function automatic logic [1:0] exp_bit(int k, logic rd, logic [4:0] phy, logic [4:0] rg,
                                           logic [15:0] wd);
        logic [13:0] hdr;
        logic [17:0] wf;
        hdr = {2'b01, (rd ? 2'b10 : 2'b01), phy, rg};
        wf  = {2'b10, wd};
        if (k < 32) return 2'b11;
        if (k < 46) return {1'b1, hdr[45-k]};
        if (!rd && k < 64) return {1'b1, wf[63-k]};
        return 2'b00;
    endfunction

    // Monitor: records the line at each rising edge, times the phases, drives the PHY bit, counts done.
    always @(negedge clk) begin
        if (req_valid && req_ready) begin
            nrise = 0;
            done_cnt = 0;
            phase_bad = 0;
            stab_bad = 0;
        end
        if (mdc != last_mdc) begin
            if (last_mdc && run_len != HALF) phase_bad++;
            if (!last_mdc && nrise > 0 && run_len != HALF) phase_bad++;
            if (mdc) begin
                if (nrise < 128) begin
                    oe_rec[nrise] = mdio_oe;
                    do_rec[nrise] = mdio_out;
                end
                mdio_in = phy_bit(nrise);
                nrise++;
            end
            run_len = 1;
        end else begin
            run_len++;
            if (mdc && nrise > 0 && nrise <= 128) begin
                if (mdio_oe !== oe_rec[nrise-1] || (mdio_oe && mdio_out !== do_rec[nrise-1]))
                    stab_bad++;
            end
        end
        last_mdc = mdc;
        if (done) begin
            done_cnt++;
            got_err = err;
            got_rd = rd_data;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act,
                       input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // One full transaction with all per-frame checks.
    task automatic txn(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wd, input logic tabad, input logic [15:0] rv,
                       input logic scramble, input logic poke);
        int t;
        int len;
        int bad_pre;
        int bad_hdr;
        int bad_tail;
        logic [1:0] e;
        @(posedge clk); #2;
        mon_read  = rd;
        mon_tabad = tabad;
        mon_rv    = rv;
        req_read  = rd;
        req_phy   = phy;
        req_reg   = rg;
        req_wdata = wd;
        req_valid = 1'b1;
        @(posedge clk); #2;
        req_valid = 1'b0;
        if (scramble) begin
            req_read  = ~rd;
            req_phy   = ~phy;
            req_reg   = ~rg;
            req_wdata = ~wd;
        end
        if (poke) begin
            repeat (40) @(posedge clk);
            #2;
            req_valid = 1'b1;
            req_read  = ~rd;
            @(posedge clk); #2;
            req_valid = 1'b0;
        end
        t = 0;
        while (done_cnt == 0 && t < 3000) begin
            @(posedge clk);
            t++;
        end
        chk(t < 3000, "R10", "watchdog for done", t, 0);
        repeat (20) @(posedge clk);
        @(negedge clk);
        len = rd ? (tabad ? 79 : 64) : 65;
        chk(nrise == len, rd ? (tabad ? "R9" : "R8") : "R7", "frame length", nrise, len);
        bad_pre = 0;
        bad_hdr = 0;
        bad_tail = 0;
        for (int k = 0; k < len && k < nrise; k++) begin
            e = exp_bit(k, rd, phy, rg, wd);
            if (oe_rec[k] !== e[1] || (e[1] && do_rec[k] !== e[0])) begin
                if (k < 32) bad_pre++;
                else if (k < 46) bad_hdr++;
                else bad_tail++;
            end
        end
        chk(bad_pre == 0, "R4", "preamble bit mismatches", bad_pre, 0);
        chk(bad_hdr == 0, scramble ? "R2/R5" : "R5", "header bit mismatches", bad_hdr, 0);
        chk(bad_tail == 0, rd ? (tabad ? "R9" : "R8") : (scramble ? "R2/R7" : "R7"),
            "turnaround/data/tail mismatches", bad_tail, 0);
        chk(done_cnt == 1, poke ? "R2/R10" : "R10", "done pulses", done_cnt, 1);
        chk(got_err == (rd && tabad), "R9", "error flag", got_err, rd && tabad);
        chk(got_rd == ((rd && !tabad) ? rv : 16'h0), rd ? "R8" : "R7", "read data", got_rd,
            (rd && !tabad) ? rv : 16'h0);
        chk(rd_data == got_rd && err == got_err, "R10", "result held after done",
            {err, rd_data}, {got_err, got_rd});
        chk(phase_bad == 0, "R3", "phase length faults", phase_bad, 0);
        chk(stab_bad == 0, "R6", "changes while clock high", stab_bad, 0);
        chk(req_ready && !mdc && !mdio_oe, "R1", "idle state after frame",
            {req_ready, mdc, mdio_oe}, 3'b100);
    endtask

    // Global watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R10 global watchdog expired: actual 0x1 expected 0x0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Stimulus.
    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_read = 1'b0;
        req_phy = '0;
        req_reg = '0;
        req_wdata = '0;
        mdio_in = 1'b1;
        repeat (5) @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !mdc && !mdio_oe && !done, "R1", "reset state",
            {req_ready, mdc, mdio_oe, done}, 4'b1000);
        chk(rd_data == 16'h0 && !err, "R10", "reset results", {err, rd_data}, 0);
        for (int a = 0; a < 32; a++) begin
            txn(1'b0, 5'(a), 5'((a * 7) % 32), 16'(a * 16'h0813) ^ 16'h5A3C, 1'b0, 16'h0,
                1'b0, 1'b0);
            txn(1'b1, 5'(31 - a), 5'(a), 16'h0, 1'b0, 16'(a * 16'h1111 + 16'h0F0F + a),
                1'b0, 1'b0);
        end
        txn(1'b0, 5'h1F, 5'h1F, 16'hFFFF, 1'b0, 16'h0, 1'b0, 1'b0);
        txn(1'b0, 5'h00, 5'h00, 16'h0000, 1'b0, 16'h0, 1'b0, 1'b0);
        txn(1'b0, 5'h10, 5'h01, 16'h8001, 1'b0, 16'h0, 1'b0, 1'b0);
        txn(1'b1, 5'h15, 5'h0A, 16'h0, 1'b0, 16'hFFFF, 1'b0, 1'b0);
        txn(1'b1, 5'h0A, 5'h15, 16'h0, 1'b0, 16'h0000, 1'b0, 1'b0);
        txn(1'b1, 5'h03, 5'h04, 16'h0, 1'b1, 16'hBEEF, 1'b0, 1'b0);
        txn(1'b1, 5'h03, 5'h04, 16'h0, 1'b0, 16'hBEEF, 1'b0, 1'b0);
        txn(1'b0, 5'h12, 5'h09, 16'hC3A5, 1'b0, 16'h0, 1'b1, 1'b0);
        txn(1'b1, 5'h07, 5'h1C, 16'h0, 1'b0, 16'h5AA5, 1'b1, 1'b0);
        txn(1'b1, 5'h0E, 5'h11, 16'h0, 1'b0, 16'h1234, 1'b0, 1'b1);
        txn(1'b1, 5'h0E, 5'h11, 16'h0, 1'b1, 16'h1234, 1'b0, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule